// File: doc/BRIEF.md
# Prioritized Peripheral Event Transfer Controller

This block moves single data words on behalf of peripheral interrupt requests, so software is not invoked for every word. Each of its channels keeps a transfer count, a source pointer and a destination pointer, all written by software through a small configuration port. A one-cycle pulse on a channel's request line marks that channel pending. A fixed-priority arbiter then selects the highest-numbered pending channel and performs one word transfer: a read from the source pointer, then a write of the same word to the destination pointer.

After each transfer the channel's count drops by one and both pointers advance by one word. While the count is still nonzero, the request is retired automatically. A count that reaches zero means the channel's buffer is full or empty. In that case the request stays pending and is raised on the channel's regular interrupt output, so software can reload the buffer. While the request waits there, it blocks every lower-priority channel. A nonzero count written to the channel re-arms it, and its pending request is then served by a transfer again.

Top module: `pet_ctrl`

## Requirements
- R1: After reset no grant is asserted, no bus read or write is issued and no interrupt output is raised.
- R2: A one-cycle high pulse on `req_i[c]` marks channel c pending. A request arriving in the same cycle that a transfer retires that channel's request leaves the channel pending, so one more transfer follows.
- R3: Among pending channels, the one with the highest index is served first. `gnt_o` is one-hot, with bit c set while channel c's transfer is in progress, and all zeros otherwise.
- R4: A transfer reads at the channel's source pointer in the cycle after it is started, then writes the data it read to the destination pointer in the next cycle. Only one transfer is in flight at a time, and arbitration resumes the cycle after the write, so back-to-back transfers start every 3 cycles.
- R5: Each transfer decrements the channel's count by one and advances its source and destination pointers by one.
- R6: When the decremented count is nonzero, the channel's request is retired, and a new request is needed for the next transfer.
- R7: When the decremented count is zero, the request stays pending, `irq_o[c]` goes high and no further transfer happens on that channel.
- R8: While the highest-priority pending channel has a zero count, no lower-priority channel is granted. Higher-priority channels are still served.
- R9: A configuration write (`cfg_sel` = 0) of a nonzero count to an exhausted channel drops its `irq_o` bit and lets its pending request be served by a transfer. `cfg_sel` = 1 writes the source pointer and 2 writes the destination pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NCH | Per-channel request pulses |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | $clog2(NCH) | Channel selected by the configuration write |
| cfg_sel | input | 2 | 0 count, 1 source pointer, 2 destination pointer |
| cfg_wdata | input | AW | Configuration write value (count uses the low CW bits) |
| gnt_o | output | NCH | One-hot grant of the channel being transferred |
| irq_o | output | NCH | Regular interrupt per exhausted, pending channel |
| bus_rd_o | output | 1 | Bus read strobe |
| bus_wr_o | output | 1 | Bus write strobe |
| bus_addr_o | output | AW | Bus word address |
| bus_wdata_o | output | DW | Bus write data |
| bus_rdata_i | input | DW | Bus read data, valid in the cycle the read strobe is high |

## Verification
Every channel is swept through its whole life in turn: served, exhausted, stalled and re-armed. A design that retired the request on the last transfer would lose the interrupt, and one that kept transferring past zero would show an extra write at the next address. All eight channels are then requested at once, and the bench checks both the descending grant order and the three-cycle cadence, which catches an inverted priority encoder or a transfer that overlaps the next. An exhausted middle channel is placed between a higher and a lower requester; a design that skipped over the blocked channel would serve the lower one early. A request timed to land on the very edge that retires the same channel checks that the new request is not swallowed by the clear.

// File: rtl/pet_ctrl.sv
module pet_ctrl #(
  parameter int NCH = 8,
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int CW  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:0]         req_i,
  input  logic                   cfg_we,
  input  logic [$clog2(NCH)-1:0] cfg_ch,
  input  logic [1:0]             cfg_sel,
  input  logic [AW-1:0]          cfg_wdata,
  output logic [NCH-1:0]         gnt_o,
  output logic [NCH-1:0]         irq_o,
  output logic                   bus_rd_o,
  output logic                   bus_wr_o,
  output logic [AW-1:0]          bus_addr_o,
  output logic [DW-1:0]          bus_wdata_o,
  input  logic [DW-1:0]          bus_rdata_i
);
  localparam int IW = $clog2(NCH);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t            st_q;
  logic [IW-1:0]  cur_q;
  logic [DW-1:0]  data_q;
  logic [NCH-1:0] pend_q;
  logic [CW-1:0]  cnt_q [NCH];
  logic [AW-1:0]  src_q [NCH];
  logic [AW-1:0]  dst_q [NCH];

  logic [IW-1:0]  top;
  logic           hit;
  logic           start;
  logic           done;
  logic [NCH-1:0] clr;

  always_comb begin
    top = '0;
    hit = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (pend_q[i]) begin
        top = IW'(i);
        hit = 1'b1;
      end
    end
  end

  assign start = (st_q == S_IDLE) && hit && (cnt_q[top] != '0);
  assign done  = (st_q == S_WR);
  assign clr   = (done && (cnt_q[cur_q] != CW'(1))) ? (NCH'(1) << cur_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cur_q  <= '0;
      data_q <= '0;
      pend_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr) | req_i;
      case (st_q)
        S_IDLE: if (start) begin
          st_q  <= S_RD;
          cur_q <= top;
        end
        S_RD: begin
          st_q   <= S_WR;
          data_q <= bus_rdata_i;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    wire sel_w = cfg_we && (cfg_ch == IW'(g));
    wire own_w = done && (cur_q == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[g] <= '0;
        src_q[g] <= '0;
        dst_q[g] <= '0;
      end else begin
        if (own_w) begin
          cnt_q[g] <= cnt_q[g] - CW'(1);
          src_q[g] <= src_q[g] + AW'(1);
          dst_q[g] <= dst_q[g] + AW'(1);
        end
        if (sel_w) begin
          case (cfg_sel)
            2'd0:    cnt_q[g] <= cfg_wdata[CW-1:0];
            2'd1:    src_q[g] <= cfg_wdata;
            2'd2:    dst_q[g] <= cfg_wdata;
            default: ;
          endcase
        end
      end
    end

    assign irq_o[g] = pend_q[g] && (cnt_q[g] == '0);
    assign gnt_o[g] = (st_q != S_IDLE) && (cur_q == IW'(g));
  end

  assign bus_rd_o    = (st_q == S_RD);
  assign bus_wr_o    = (st_q == S_WR);
  assign bus_addr_o  = (st_q == S_RD) ? src_q[cur_q] : dst_q[cur_q];
  assign bus_wdata_o = data_q;
endmodule

// File: rtl/pet_ctrl_chk.sv
module pet_ctrl_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_we,
  input logic [NCH-1:0] gnt_o,
  input logic [NCH-1:0] irq_o,
  input logic           bus_rd_o,
  input logic           bus_wr_o
);
  logic [NCH-1:0] above;
  assign above = ~((gnt_o << 1) - {{(NCH-1){1'b0}}, 1'b1});

  a_r3_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  a_r4_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd_o && bus_wr_o));

  a_r4_read_before_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_o |-> $past(bus_rd_o) && $stable(gnt_o));

  a_r4_gap_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_o |=> !bus_rd_o && !bus_wr_o);

  a_r7_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ((irq_o & $past(irq_o)) == $past(irq_o)));

  a_r8_no_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd_o) |-> (($past(irq_o) & above) == '0));
endmodule

bind pet_ctrl pet_ctrl_chk #(.NCH(NCH)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_we   (cfg_we),
  .gnt_o    (gnt_o),
  .irq_o    (irq_o),
  .bus_rd_o (bus_rd_o),
  .bus_wr_o (bus_wr_o)
);

// File: tb/pet_ctrl_tb_top.sv
module pet_ctrl_tb_top;
  localparam int NCH = 8;
  localparam int AW  = 16;
  localparam int DW  = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] req_i = '0;
  logic           cfg_we = 1'b0;
  logic [2:0]     cfg_ch = '0;
  logic [1:0]     cfg_sel = '0;
  logic [AW-1:0]  cfg_wdata = '0;
  logic [NCH-1:0] gnt_o, irq_o;
  logic           bus_rd_o, bus_wr_o;
  logic [AW-1:0]  bus_addr_o;
  logic [DW-1:0]  bus_wdata_o, bus_rdata_i;

  always #2 clk = ~clk;

  function automatic logic [15:0] memf(logic [15:0] a);
    return a * 16'd3 + 16'h1234;
  endfunction

  assign bus_rdata_i = memf(bus_addr_o);

  pet_ctrl #(.NCH(NCH), .AW(AW), .DW(DW), .CW(8)) dut_i (
    .clk, .rst_n, .req_i, .cfg_we, .cfg_ch, .cfg_sel, .cfg_wdata,
    .gnt_o, .irq_o, .bus_rd_o, .bus_wr_o, .bus_addr_o, .bus_wdata_o, .bus_rdata_i
  );

  int n_chk = 0, n_fail = 0, cyc = 0, nlog = 0;
  int lg_ch [64], lg_addr [64], lg_data [64], lg_src [64], lg_cyc [64];
  int last_rd = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (bus_rd_o) last_rd = bus_addr_o;
    if (bus_wr_o && nlog < 64) begin
      lg_ch[nlog] = -1;
      for (int i = 0; i < NCH; i++) if (gnt_o[i]) lg_ch[nlog] = i;
      lg_addr[nlog] = bus_addr_o;
      lg_data[nlog] = bus_wdata_o;
      lg_src[nlog]  = last_rd;
      lg_cyc[nlog]  = cyc;
      nlog++;
    end
  end

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic wcfg(int ch, int sel, int val);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_sel = 2'(sel); cfg_wdata = AW'(val);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic pulse(logic [NCH-1:0] m);
    @(posedge clk); #1;
    req_i = m;
    @(posedge clk); #1;
    req_i = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic int srcb(int c); return 16'h0100 + c * 64; endfunction
  function automatic int dstb(int c); return 16'h0800 + c * 64; endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    chk("R1 grant", gnt_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 bus_rd", bus_rd_o, 0);
    chk("R1 bus_wr", bus_wr_o, 0);
    rst_n = 1'b1;
    idle(2);
    chk("R1 irq after release", irq_o, 0);

    // Sweep: serve, exhaust, stall each channel
    for (int c = 0; c < NCH; c++) begin
      wcfg(c, 0, 2);
      wcfg(c, 1, srcb(c));
      wcfg(c, 2, dstb(c));
      nlog = 0;
      pulse(NCH'(1) << c);
      idle(8);
      chk("R2 one transfer", nlog, 1);
      chk("R3 grant channel", lg_ch[0], c);
      chk("R4 read address", lg_src[0], srcb(c));
      chk("R4 write address", lg_addr[0], dstb(c));
      chk("R4 write data", lg_data[0], memf(16'(srcb(c))));
      chk("R6 no irq", irq_o[c], 0);
      idle(4);
      chk("R6 retired", nlog, 1);
      pulse(NCH'(1) << c);
      idle(8);
      chk("R5 second transfer", nlog, 2);
      chk("R5 dst advanced", lg_addr[1], dstb(c) + 1);
      chk("R5 src advanced", lg_data[1], memf(16'(srcb(c) + 1)));
      chk("R7 irq raised", irq_o[c], 1);
      pulse(NCH'(1) << c);
      idle(8);
      chk("R7 stalled", nlog, 2);
    end
    chk("R7 all irq", irq_o, 8'hFF);

    // Re-arm all, highest first
    nlog = 0;
    for (int c = NCH - 1; c >= 0; c--) wcfg(c, 0, 4);
    idle(40);
    chk("R9 irq cleared", irq_o, 0);
    chk("R9 transfers", nlog, 8);
    for (int i = 0; i < 8; i++) begin
      chk("R9 order", lg_ch[i], 7 - i);
      chk("R5 third address", lg_addr[i], dstb(7 - i) + 2);
    end

    // All requests at once
    nlog = 0;
    pulse(8'hFF);
    idle(40);
    chk("R3 transfers", nlog, 8);
    for (int i = 0; i < 8; i++) chk("R3 priority order", lg_ch[i], 7 - i);
    for (int i = 0; i < 7; i++) chk("R4 cadence", lg_cyc[i + 1] - lg_cyc[i], 3);

    // Stall of lower channels behind exhausted channel 5
    pulse(8'h20); idle(8);
    pulse(8'h20); idle(8);
    chk("R7 ch5 exhausted", irq_o, 8'h20);
    nlog = 0;
    pulse(8'h44);
    idle(20);
    chk("R8 only higher served", nlog, 1);
    chk("R8 higher channel", lg_ch[0], 6);
    chk("R8 ch5 still blocking", irq_o, 8'h20);
    wcfg(5, 0, 3);
    idle(20);
    chk("R9 resumed transfers", nlog, 3);
    chk("R9 ch5 first", lg_ch[1], 5);
    chk("R8 ch2 after", lg_ch[2], 2);
    chk("R9 irq gone", irq_o, 0);

    // Request landing on the retiring edge
    nlog = 0;
    pulse(8'h02);
    repeat (2) @(posedge clk);
    #1; req_i = 8'h02;
    @(posedge clk); #1; req_i = '0;
    idle(12);
    chk("R2 set beats clear", nlog, 2);
    chk("R2 channel", lg_ch[1], 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule